// File: doc/BRIEF.md
# CAN Mode Acknowledge Controller

This block produces the handshakes that software sees when it puts a CAN controller into initialization or sleep mode and then takes it out again. Software raises a request bit and the matching acknowledge answers one clock later. When software withdraws the request, the acknowledge stays high until the controller has seen the bus idle. Bus idle means a run of consecutive recessive bits on the receive line, sampled only on a bit-time strobe. A dominant sample restarts the run.

The same block holds the error interrupt flag. The flag is raised by a new error-status event whose individual enable is on, and only a software clear pulse lowers it. A status-change interrupt line follows the flag, gated by a global enable. Frame handling, bit timing and wakeup on bus activity are done elsewhere.

Top module: `can_mode_ack`

## Requirements
- R1: While reset is active and on the first cycle after it, init_ack_o is 1, sleep_ack_o is 0, err_irq_o is 0 and stat_irq_o is 0.
- R2: A high init_req_i in any mode makes init_ack_o 1 and sleep_ack_o 0 on the next cycle.
- R3: In normal mode, a high sleep_req_i with init_req_i low makes sleep_ack_o 1 on the next cycle.
- R4: After init_req_i drops, init_ack_o stays 1 until the IDLE_BITS-th consecutive recessive sample (rx_i = 1 on a bit_stb_i cycle). It falls on the cycle after that sample. The default IDLE_BITS is 11.
- R5: After sleep_req_i drops, sleep_ack_o follows the same rule as R4.
- R6: A dominant sample (rx_i = 0 on a bit_stb_i cycle) during the idle count restarts the run from zero.
- R7: rx_i has no effect on cycles where bit_stb_i is low.
- R8: If sleep_req_i rises again while sleep mode is being left, the block returns to sleep mode. The idle run then starts over when the request next drops. A rising init_req_i during either exit goes to initialization mode.
- R9: If both requests are high in normal mode, initialization mode is entered.
- R10: err_irq_o rises on the cycle after bit i of err_stat_i changes from 0 to 1 while bit i of err_en_i is 1. A set on the same cycle as err_clr_i wins over the clear.
- R11: err_irq_o stays at 1 until a cycle with err_clr_i high. A status bit that falls, or one held at 1, neither clears the flag nor raises it again.
- R12: stat_irq_o equals err_irq_o AND err_ie_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_req_i | input | 1 | Software initialization request |
| sleep_req_i | input | 1 | Software sleep request |
| bit_stb_i | input | 1 | One-cycle pulse once per bit time |
| rx_i | input | 1 | Serial receive line (1 = recessive) |
| err_stat_i | input | N_ERR | Error-detection status bits |
| err_en_i | input | N_ERR | Per-bit error interrupt enables |
| err_ie_i | input | 1 | Global error interrupt enable |
| err_clr_i | input | 1 | Software clear of the error flag |
| init_ack_o | output | 1 | Initialization acknowledge |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| err_irq_o | output | 1 | Error interrupt flag |
| stat_irq_o | output | 1 | Status-change interrupt |

## Verification
The hardest case to reach from the ports is an exit interrupted exactly one sample before it completes: a dominant bit at every position of the run, followed by a full fresh run. The stimulus sweeps the position of the dominant sample across the run. Between strobes it drives dominant levels on cycles with no strobe. It then counts the samples needed before the acknowledge falls. The error flag is swept over every pairing of status and enable patterns, including a set and a clear that arrive together.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [2:0] {
      MODE_INIT       = 3'd0,
      MODE_INIT_EXIT  = 3'd1,
      MODE_NORMAL     = 3'd2,
      MODE_SLEEP      = 3'd3,
      MODE_SLEEP_EXIT = 3'd4
   } can_mode_e;

   function automatic logic mode_is_exit(can_mode_e m);
      return (m == MODE_INIT_EXIT) || (m == MODE_SLEEP_EXIT);
   endfunction

endpackage

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic stb_i,
   input  logic rx_i,
   output logic done_o
);

   localparam int CNT_W = $clog2(IDLE_BITS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

   if (IDLE_BITS < 2) begin : g_bad_idle
      $error("IDLE_BITS must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (stb_i) begin
         if (!rx_i)             cnt_q <= '0;
         else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = en_i && stb_i && rx_i && (cnt_q == LAST);

   a_r7_hold_between_strobes : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !stb_i) |=> (cnt_q == $past(cnt_q)));

   a_r6_dominant_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && stb_i && !rx_i) |=> !done_o);

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic init_req_i,
   input  logic sleep_req_i,
   input  logic idle_done_i,
   output logic exit_en_o,
   output logic init_ack_o,
   output logic sleep_ack_o
);

   can_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_INIT: begin
            if (!init_req_i) mode_d = MODE_INIT_EXIT;
         end
         MODE_INIT_EXIT: begin
            if (init_req_i)       mode_d = MODE_INIT;
            else if (idle_done_i) mode_d = MODE_NORMAL;
         end
         MODE_NORMAL: begin
            if (init_req_i)       mode_d = MODE_INIT;
            else if (sleep_req_i) mode_d = MODE_SLEEP;
         end
         MODE_SLEEP: begin
            if (init_req_i)        mode_d = MODE_INIT;
            else if (!sleep_req_i) mode_d = MODE_SLEEP_EXIT;
         end
         MODE_SLEEP_EXIT: begin
            if (init_req_i)       mode_d = MODE_INIT;
            else if (sleep_req_i) mode_d = MODE_SLEEP;
            else if (idle_done_i) mode_d = MODE_NORMAL;
         end
         default: mode_d = MODE_INIT;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= MODE_INIT;
      else         mode_q <= mode_d;
   end

   assign exit_en_o   = mode_is_exit(mode_q);
   assign init_ack_o  = (mode_q == MODE_INIT) || (mode_q == MODE_INIT_EXIT);
   assign sleep_ack_o = (mode_q == MODE_SLEEP) || (mode_q == MODE_SLEEP_EXIT);

   a_r2_init_entry : assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_req_i |=> (init_ack_o && !sleep_ack_o));

   a_r9_init_priority : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_req_i && sleep_req_i) |=> !sleep_ack_o);

   a_r3_sleep_entry : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_ack_o && !sleep_ack_o && sleep_req_i && !init_req_i) |=> sleep_ack_o);

   a_r4_init_ack_fall : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(init_ack_o) |-> $past(idle_done_i));

   a_r5_sleep_ack_fall : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sleep_ack_o) |-> ($past(idle_done_i) || $past(init_req_i)));

endmodule

// File: rtl/can_err_flag.sv
module can_err_flag #(
   parameter int N_ERR    = 3,
   parameter bit ERR_EDGE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_ERR-1:0] stat_i,
   input  logic [N_ERR-1:0] en_i,
   input  logic             clr_i,
   output logic             flag_o
);

   if (N_ERR < 1) begin : g_bad_nerr
      $error("N_ERR must be at least 1");
   end

   logic hit;
   logic flag_q;

   if (ERR_EDGE) begin : g_edge
      logic [N_ERR-1:0] prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q <= '0;
         else         prev_q <= stat_i;
      end
      assign hit = |(stat_i & ~prev_q & en_i);
   end else begin : g_level
      assign hit = |(stat_i & en_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   a_r10_flag_set : assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> flag_o);

   a_r11_sw_clear_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o) |-> $past(clr_i));

endmodule

// File: rtl/can_mode_ack.sv
module can_mode_ack #(
   parameter int N_ERR     = 3,
   parameter int IDLE_BITS = 11,
   parameter bit ERR_EDGE  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_req_i,
   input  logic             sleep_req_i,
   input  logic             bit_stb_i,
   input  logic             rx_i,
   input  logic [N_ERR-1:0] err_stat_i,
   input  logic [N_ERR-1:0] err_en_i,
   input  logic             err_ie_i,
   input  logic             err_clr_i,
   output logic             init_ack_o,
   output logic             sleep_ack_o,
   output logic             err_irq_o,
   output logic             stat_irq_o
);

   logic exit_en;
   logic idle_done;

   can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (exit_en),
      .stb_i  (bit_stb_i),
      .rx_i   (rx_i),
      .done_o (idle_done)
   );

   can_mode_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_req_i  (init_req_i),
      .sleep_req_i (sleep_req_i),
      .idle_done_i (idle_done),
      .exit_en_o   (exit_en),
      .init_ack_o  (init_ack_o),
      .sleep_ack_o (sleep_ack_o)
   );

   can_err_flag #(.N_ERR(N_ERR), .ERR_EDGE(ERR_EDGE)) u_err (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stat_i (err_stat_i),
      .en_i   (err_en_i),
      .clr_i  (err_clr_i),
      .flag_o (err_irq_o)
   );

   assign stat_irq_o = err_irq_o & err_ie_i;

   a_r12_irq_needs_flag : assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_irq_o |-> (err_irq_o && err_ie_i));

endmodule

// File: tb/can_mode_ack_tb.sv
module can_mode_ack_tb;

   localparam int NE   = 3;
   localparam int IDLE = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_req = 1'b1, sleep_req = 1'b0, stb = 1'b0, rx = 1'b1;
   logic [NE-1:0] stat = '0, en = '0;
   logic ie = 1'b0, clr = 1'b0;
   logic init_ack, sleep_ack, err_irq, stat_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   can_mode_ack #(.N_ERR(NE), .IDLE_BITS(IDLE), .ERR_EDGE(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .init_req_i(init_req), .sleep_req_i(sleep_req),
      .bit_stb_i(stb), .rx_i(rx), .err_stat_i(stat), .err_en_i(en),
      .err_ie_i(ie), .err_clr_i(clr), .init_ack_o(init_ack),
      .sleep_ack_o(sleep_ack), .err_irq_o(err_irq), .stat_irq_o(stat_irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one strobed sample, then a non-strobe cycle with a dominant level (R7)
   task automatic sample(input logic v);
      stb = 1'b1; rx = v;
      tick();
      stb = 1'b0; rx = 1'b0;
      tick();
      rx = 1'b1;
   endtask

   task automatic recessive(input int n);
      for (int i = 0; i < n; i++) sample(1'b1);
   endtask

   task automatic enter_sleep_and_withdraw();
      sleep_req = 1'b1; tick();
      sleep_req = 1'b0; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1 during reset
      chk("R1 init_ack in reset", init_ack, 1);
      chk("R1 sleep_ack in reset", sleep_ack, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 init_ack after reset", init_ack, 1);
      chk("R1 sleep_ack after reset", sleep_ack, 0);
      chk("R1 err_irq after reset", err_irq, 0);
      chk("R1 stat_irq after reset", stat_irq, 0);

      // R4 / R7: leave init mode
      init_req = 1'b0; tick();
      recessive(IDLE - 1);
      chk("R4 R7 init_ack held before last sample", init_ack, 1);
      sample(1'b1);
      chk("R4 init_ack drops after full run", init_ack, 0);
      chk("R4 sleep_ack low in normal", sleep_ack, 0);

      // R3 / R5
      sleep_req = 1'b1; tick();
      chk("R3 sleep_ack set", sleep_ack, 1);
      chk("R3 init_ack low in sleep", init_ack, 0);
      sleep_req = 1'b0; tick();
      chk("R5 sleep_ack held on withdraw", sleep_ack, 1);
      recessive(IDLE - 1);
      chk("R5 sleep_ack held before last sample", sleep_ack, 1);
      sample(1'b1);
      chk("R5 sleep_ack drops after full run", sleep_ack, 0);

      // R6: dominant sample at every position of the run
      for (int k = 0; k < IDLE; k++) begin
         enter_sleep_and_withdraw();
         recessive(k);
         sample(1'b0);
         recessive(IDLE - 1);
         chk($sformatf("R6 held after restart k=%0d", k), sleep_ack, 1);
         sample(1'b1);
         chk($sformatf("R6 drop after fresh run k=%0d", k), sleep_ack, 0);
      end

      // R8: re-request sleep during exit
      enter_sleep_and_withdraw();
      recessive(IDLE - 2);
      sleep_req = 1'b1; tick();
      chk("R8 back in sleep", sleep_ack, 1);
      sleep_req = 1'b0; tick();
      recessive(IDLE - 1);
      chk("R8 count restarted", sleep_ack, 1);
      sample(1'b1);
      chk("R8 drop after full run", sleep_ack, 0);

      // R8 / R2: init request during sleep exit
      enter_sleep_and_withdraw();
      recessive(3);
      init_req = 1'b1; tick();
      chk("R2 R8 init_ack from sleep exit", init_ack, 1);
      chk("R2 R8 sleep_ack cleared", sleep_ack, 0);
      init_req = 1'b0; tick();
      recessive(IDLE);
      chk("R4 leave init again", init_ack, 0);

      // R9: both requests in normal mode
      init_req = 1'b1; sleep_req = 1'b1; tick();
      chk("R9 init wins init_ack", init_ack, 1);
      chk("R9 init wins sleep_ack", sleep_ack, 0);
      tick();
      chk("R9 stays in init", sleep_ack, 0);
      init_req = 1'b0; tick();
      chk("R4 sleep ignored during init exit", sleep_ack, 0);
      recessive(IDLE);
      tick();
      chk("R3 sleep entered from normal after init exit", sleep_ack, 1);
      // R2: init request from sleep
      init_req = 1'b1; tick();
      chk("R2 init from sleep", init_ack, 1);
      chk("R2 sleep_ack cleared from sleep", sleep_ack, 0);
      sleep_req = 1'b0; init_req = 1'b0; tick();
      recessive(IDLE);
      chk("R4 back to normal", init_ack, 0);

      // R10 / R11 / R12: sweep over status and enables
      for (int s = 0; s < (1 << NE); s++) begin
         for (int e = 0; e < (1 << NE); e++) begin
            logic exp_f;
            exp_f = |(s[NE-1:0] & e[NE-1:0]);
            stat = '0; en = e[NE-1:0]; ie = 1'b0; clr = 1'b1; tick();
            clr = 1'b0;
            chk("R11 cleared by software", err_irq, 0);
            stat = s[NE-1:0]; tick();
            chk($sformatf("R10 set s=%0d e=%0d", s, e), err_irq, exp_f);
            chk("R12 gated off", stat_irq, 0);
            ie = 1'b1; #1;
            chk($sformatf("R12 gated on s=%0d e=%0d", s, e), stat_irq, exp_f);
            stat = '0; tick();
            chk("R11 held after status falls", err_irq, exp_f);
         end
      end

      // R10: set beats clear; R11: held level does not retrigger
      ie = 1'b0; en = '1; stat = '0; clr = 1'b1; tick();
      stat = 3'b010; tick();
      chk("R10 set wins over clear", err_irq, 1);
      tick();
      chk("R11 clear with level held", err_irq, 0);
      clr = 1'b0;
      repeat (4) tick();
      chk("R11 held level no retrigger", err_irq, 0);
      stat = 3'b110; tick();
      chk("R10 new bit rising sets", err_irq, 1);
      repeat (5) tick();
      chk("R11 stays without clear", err_irq, 1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule